// File: doc/BRIEF.md
# Split-Point Variable Length Adder

This block adds two unsigned n-bit words as two separate sums that sit side by side in one result word. A small control value chosen at run time sets a boundary bit position p. Bits below p form a low field and bits from p upward form a high field. Each field is added on its own and reports its own carry-out. No carry crosses from the low field into the high field.

The block is purely combinational. The word width is n = 2^k, where k is the width of the boundary select. The default build is k = 2, which gives a 4-bit adder with boundaries 0 to 3. When the boundary is 0 the low field is empty. The whole word is then added as the high field.

Top module: `vla_split_adder`

## Requirements
- R1: The boundary p equals the unsigned value of `split`. Result bits below p belong to the low field, and bits p through n-1 belong to the high field.
- R2: Changing operand bits below p leaves the high-field result bits and `high_carry` unchanged. No carry passes into bit p.
- R3: The low field satisfies opa[p-1:0] + opb[p-1:0] = sum[p-1:0] + 2^p * `low_carry`.
- R4: The high field satisfies opa[n-1:p] + opb[n-1:p] = sum[n-1:p] + 2^(n-p) * `high_carry`. `high_carry` is the carry out of bit n-1.
- R5: When `split` is 0, `low_carry` is 0, `sum` is the full n-bit sum, and `high_carry` is its carry-out.
- R6: Changing operand bits at or above p leaves the low-field result bits and `low_carry` unchanged.
- R7: The outputs depend only on the present inputs, with no state and no latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | N (2^K) | First unsigned operand |
| opb | input | N (2^K) | Second unsigned operand |
| split | input | K | Boundary position p, unsigned |
| sum | output | N | Low-field sum below p, high-field sum from p upward |
| low_carry | output | 1 | Carry out of bit p-1; 0 when p is 0 |
| high_carry | output | 1 | Carry out of bit n-1 |

## Verification
The assertions evaluate the low-field and high-field equations every time an input changes. They also check that the boundary decode is one-hot and that an empty low field yields a zero `low_carry`. Those assertions cannot show that the two fields are isolated from each other, which is what R2 and R6 require. Only the bench shows that, by perturbing the operand bits on one side of the boundary and comparing the other side's result bits and carry against the unperturbed run. The bench sweeps every operand pair and every boundary for the 4-bit build.

// File: rtl/vla_pkg.sv
package vla_pkg;
  // Field mask: bits strictly below the boundary set
  function automatic int unsigned low_bits_below(input int unsigned pos);
    return pos;
  endfunction
endpackage

// File: rtl/vla_boundary_decode.sv
module vla_boundary_decode #(
  parameter int K = 2,
  localparam int N = 1 << K
) (
  input  logic [K-1:0] split,
  output logic [N-1:0] cut_onehot,
  output logic [N-1:0] low_mask
);
  always_comb begin
    for (int i = 0; i < N; i++) begin
      cut_onehot[i] = (int'(split) == i);
      low_mask[i]   = (i < int'(split));
    end
  end

  always_comb begin
    p_cut_onehot_r1: assert ($onehot(cut_onehot))
      else $error("boundary decode not one-hot");
    p_mask_edge_r1: assert ((low_mask & cut_onehot) == '0)
      else $error("boundary bit marked as low field");
  end
endmodule

// File: rtl/vla_carry_chain.sv
module vla_carry_chain #(
  parameter int N = 4
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [N-1:0] cut_onehot,
  output logic [N-1:0] s,
  output logic [N-1:0] cout
);
  // Ripple chain kept in one process so the carry vector settles in a
  // single evaluation pass.
  always_comb begin
    logic c;
    logic cin;
    c = 1'b0;
    for (int i = 0; i < N; i++) begin
      cin     = cut_onehot[i] ? 1'b0 : c;
      s[i]    = a[i] ^ b[i] ^ cin;
      c       = (a[i] & b[i]) | (cin & (a[i] ^ b[i]));
      cout[i] = c;
    end
  end
endmodule

// File: rtl/vla_flag_select.sv
module vla_flag_select #(
  parameter int  K          = 2,
  parameter bit  ONEHOT_SEL = 1'b1,
  localparam int N          = 1 << K
) (
  input  logic [K-1:0] split,
  input  logic [N-1:0] cut_onehot,
  input  logic [N-1:0] cout,
  output logic         d_flag,
  output logic         e_flag
);
  assign e_flag = cout[N-1];

  generate
    if (ONEHOT_SEL) begin : g_onehot
      // Carry of bit p-1 picked by the decode shifted down one place
      logic [N-1:0] edge_sel;
      assign edge_sel = cut_onehot >> 1;
      assign d_flag   = |(cout & edge_sel);
    end else begin : g_index
      logic [K-1:0] idx;
      assign idx    = split - K'(1);
      assign d_flag = (split != '0) & cout[idx];
    end
  endgenerate

  always_comb begin
    p_empty_low_r5: assert (!(split == '0 && d_flag))
      else $error("low carry set with empty low field");
  end
endmodule

// File: rtl/vla_split_adder.sv
module vla_split_adder #(
  parameter int  K          = 2,
  parameter bit  ONEHOT_SEL = 1'b1,
  localparam int N          = 1 << K
) (
  input  logic [N-1:0] opa,
  input  logic [N-1:0] opb,
  input  logic [K-1:0] split,
  output logic [N-1:0] sum,
  output logic         low_carry,
  output logic         high_carry
);
  localparam int W1 = N + 1;

  logic [N-1:0] cut_onehot;
  logic [N-1:0] low_mask;
  logic [N-1:0] cout;

  vla_boundary_decode #(.K(K)) u_dec (
    .split      (split),
    .cut_onehot (cut_onehot),
    .low_mask   (low_mask)
  );

  vla_carry_chain #(.N(N)) u_chain (
    .a          (opa),
    .b          (opb),
    .cut_onehot (cut_onehot),
    .s          (sum),
    .cout       (cout)
  );

  vla_flag_select #(.K(K), .ONEHOT_SEL(ONEHOT_SEL)) u_flag (
    .split      (split),
    .cut_onehot (cut_onehot),
    .cout       (cout),
    .d_flag     (low_carry),
    .e_flag     (high_carry)
  );

  // Field equations checked arithmetically at the ports
  always_comb begin
    logic [W1-1:0] lo_lhs, lo_rhs, hi_lhs, hi_rhs;
    lo_lhs = W1'(opa & low_mask) + W1'(opb & low_mask);
    lo_rhs = W1'(sum & low_mask) | (W1'(low_carry) << split);
    hi_lhs = (W1'(opa >> split) + W1'(opb >> split)) << split;
    hi_rhs = {high_carry, sum & ~low_mask};
    p_low_field_r3: assert (lo_lhs == lo_rhs)
      else $error("low field equation broken");
    p_high_field_r4: assert (hi_lhs == hi_rhs)
      else $error("high field equation broken");
  end
endmodule

// File: tb/vla_split_adder_tb.sv
module vla_split_adder_tb;
  localparam int K = 2;
  localparam int N = 1 << K;

  logic clk;
  logic rst_n;
  logic [N-1:0] opa, opb, sum;
  logic [K-1:0] split;
  logic low_carry, high_carry;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  vla_split_adder #(.K(K)) u_dut (
    .opa(opa), .opb(opb), .split(split),
    .sum(sum), .low_carry(low_carry), .high_carry(high_carry)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s a=%0d b=%0d p=%0d actual=%0d expected=%0d",
               req, opa, opb, split, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input int p);
    @(negedge clk);
    opa = N'(a); opb = N'(b); split = K'(p);
    @(posedge clk);
    #2;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int full, mask;
    full = (1 << N) - 1;
    rst_n = 1'b0; opa = '0; opb = '0; split = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #2;
    // Idle inputs: zero result, no carries (R7, R5)
    check("R7 idle sum", int'(sum), 0);
    check("R5 idle low_carry", int'(low_carry), 0);
    check("R7 idle high_carry", int'(high_carry), 0);

    for (int p = 0; p < N; p++) begin
      mask = (1 << p) - 1;
      for (int a = 0; a <= full; a++) begin
        for (int b = 0; b <= full; b++) begin
          int lo, hi, e_lo, e_d, e_hi, e_e, s_lo, s_hi, d0, e0;
          lo   = (a & mask) + (b & mask);
          e_lo = lo & mask;
          e_d  = (lo >> p) & 1;
          hi   = (a >> p) + (b >> p);
          e_hi = (hi << p) & full;
          e_e  = (hi >> (N - p)) & 1;
          apply(a, b, p);
          check("R3 low sum bits", int'(sum) & mask, e_lo);
          check("R3 low_carry", int'(low_carry), e_d);
          check("R4 high sum bits", int'(sum) & ~mask & full, e_hi);
          check("R4 high_carry", int'(high_carry), e_e);
          if (p == 0) begin
            check("R5 full-width sum", int'(sum), (a + b) & full);
            check("R5 low_carry zero", int'(low_carry), 0);
            check("R5 full carry", int'(high_carry), ((a + b) >> N) & 1);
          end
          s_lo = int'(sum) & mask;
          s_hi = int'(sum) & ~mask & full;
          d0   = int'(low_carry);
          e0   = int'(high_carry);
          if (p > 0) begin
            // Flip all low bits of both operands (R2, R1)
            apply(a ^ mask, b ^ mask, p);
            check("R2 high bits isolated", int'(sum) & ~mask & full, s_hi);
            check("R2 high_carry isolated", int'(high_carry), e0);
            // Flip all high bits of both operands (R6, R1)
            apply(a ^ (~mask & full), b ^ (~mask & full), p);
            check("R6 low bits isolated", int'(sum) & mask, s_lo);
            check("R6 low_carry isolated", int'(low_carry), d0);
          end
        end
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule